// File: doc/BRIEF.md
# Carry-Save Array Multiply-Add Unit

This block is an unsigned datapath that forms a product and folds three more terms into it in one pass. Every cycle it adds a 2W-bit addend, the W-bit product of two operands, a W-bit side operand and a single carry bit weighted by 2^W. The full result comes out as a 2W-bit word plus a carry bit, so nothing is ever lost to overflow.

The product is reduced in a cascade of carry-save rows, one row per bit of the second operand. Each cell of a row takes one partial-product bit, one incoming sum bit and one incoming carry bit. It returns a sum bit in place and a carry bit one position up. The addend seeds the sum vector and the side operand seeds the carry vector. Once the last row is done, the lower W bits are already final. The upper W bits are resolved by a carry-lookahead adder built from 4-bit groups. The weighted carry bit enters that adder as its carry-in.

An optional output register holds the result for one clock. The register is on by default, and the block is typically placed inside a wider datapath that expects a result one cycle after the operands are presented.

Top module: `fused_mul_add`

## Requirements
- R1: For all unsigned inputs, {carry_out, result} equals addend + op_a*op_b + op_c + carry_in*2^W exactly, with carry_out as bit 2W of that sum.
- R2: With REG_OUT = 1, the result for operands presented before a rising clock edge appears on the outputs after that edge and holds until the next edge, so back-to-back operands give back-to-back results.
- R3: While rst_n is low, result and carry_out are zero (asynchronous, active low), whatever the operand inputs are.
- R4: The lower W bits of result do not depend on carry_in: two operand sets that differ only in carry_in give the same result[W-1:0].
- R5: carry_out is 1 exactly when the total reaches 2^(2W): for W = 4, all inputs at their maximum with carry_in = 1 give carry_out = 1 and result = 8'hFF; addend = 8'hFF with op_c = 1 and no product gives carry_out = 1 and result = 8'h00.
- R6: The carry-lookahead adder keeps the result exact when the upper half spans more than one 4-bit group (W = 8).
- R7: With all operands zero and carry_in = 1, the result is exactly 2^W (8'h10 for W = 4) and carry_out is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | W | Multiplicand |
| op_b | input | W | Multiplier, one carry-save row per bit |
| op_c | input | W | Side operand added at weight 1 |
| addend | input | 2W | Wide addend |
| carry_in | input | 1 | Carry bit added at weight 2^W |
| result | output | 2W | Lower 2W bits of the total |
| carry_out | output | 1 | Bit 2W of the total |

## Verification
The assertions assume the operand inputs stay at known 0/1 values at every rising edge once reset is released. They also assume that reset is only released between edges. The bench changes every input on the falling edge only, and it holds the operands at fixed known values while reset is low. It releases reset on a falling edge, so every sampled operand set is a fully defined unsigned value.

// File: rtl/fused_mul_add.sv
module fused_mul_add #(
  parameter int W = 4,
  parameter bit REG_OUT = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [W-1:0]    op_a,
  input  logic [W-1:0]    op_b,
  input  logic [W-1:0]    op_c,
  input  logic [2*W-1:0]  addend,
  input  logic            carry_in,
  output logic [2*W-1:0]  result,
  output logic            carry_out
);

  localparam int W2 = 2 * W;
  localparam int NG = (W + 3) / 4;
  localparam int WP = NG * 4;

  // carry-save state entering each row
  logic [W2-1:0] sv [W+1];
  logic [W2-1:0] cv [W+1];

  assign sv[0] = addend;
  assign cv[0] = {{W{1'b0}}, op_c};

  for (genvar r = 0; r < W; r++) begin : g_row
    logic [W2-1:0] s_nx;
    logic [W2-1:0] c_nx;
    logic [W-1:0]  cy;

    for (genvar k = 0; k < W2; k++) begin : g_cell
      if (k >= r && k < r + W) begin : g_fa
        logic pp;
        assign pp      = op_a[k-r] & op_b[r];
        assign s_nx[k] = pp ^ sv[r][k] ^ cv[r][k];
        assign cy[k-r] = (pp & sv[r][k]) | (pp & cv[r][k]) | (sv[r][k] & cv[r][k]);
      end else begin : g_pass
        assign s_nx[k] = sv[r][k];
      end

      if (k == r) begin : g_eat
        assign c_nx[k] = 1'b0;
      end else if (k > r && k <= r + W) begin : g_up
        assign c_nx[k] = cy[k-r-1];
      end else begin : g_keep
        assign c_nx[k] = cv[r][k];
      end
    end

    assign sv[r+1] = s_nx;
    assign cv[r+1] = c_nx;
  end

  // low half is settled after the last row; its carry slots are drained
  logic [W-1:0] lo_half;
  assign lo_half = sv[W][W-1:0] ^ cv[W][W-1:0];

  // carry-lookahead adder on the upper half, 4-bit groups
  logic [WP-1:0] ga;
  logic [WP-1:0] pa;
  logic [WP:0]   cb;
  logic [W-1:0]  hi_half;

  assign ga    = WP'(sv[W][W2-1:W] & cv[W][W2-1:W]);
  assign pa    = WP'(sv[W][W2-1:W] ^ cv[W][W2-1:W]);
  assign cb[0] = carry_in;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    localparam int B = 4 * g;
    logic [3:0] gg;
    logic [3:0] gp;
    logic       ci;
    logic       grp_g;
    logic       grp_p;

    assign gg = ga[B+3:B];
    assign gp = pa[B+3:B];
    assign ci = cb[B];

    assign cb[B+1] = gg[0] | (gp[0] & ci);
    assign cb[B+2] = gg[1] | (gp[1] & gg[0]) | (gp[1] & gp[0] & ci);
    assign cb[B+3] = gg[2] | (gp[2] & gg[1]) | (gp[2] & gp[1] & gg[0])
                   | (gp[2] & gp[1] & gp[0] & ci);

    assign grp_g = gg[3] | (gp[3] & gg[2]) | (gp[3] & gp[2] & gg[1])
                 | (gp[3] & gp[2] & gp[1] & gg[0]);
    assign grp_p = &gp;

    assign cb[B+4] = grp_g | (grp_p & ci);
  end

  assign hi_half = pa[W-1:0] ^ cb[W-1:0];

  logic [W2-1:0] res_c;
  logic          cout_c;

  assign res_c  = {hi_half, lo_half};
  assign cout_c = cb[W];

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        result    <= '0;
        carry_out <= 1'b0;
      end else begin
        result    <= res_c;
        carry_out <= cout_c;
      end
    end
  end else begin : g_comb
    assign result    = res_c;
    assign carry_out = cout_c;
  end

  // arithmetic reference for the checks below
  logic [W2:0] ref_sum;
  assign ref_sum = (W2+1)'(addend) + (W2+1)'(op_a) * (W2+1)'(op_b)
                 + (W2+1)'(op_c) + ((W2+1)'(carry_in) << W);

  p_exact_r1: assert property (@(posedge clk) disable iff (!rst_n)
    {cout_c, res_c} == ref_sum);

  p_array_keeps_sum_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((W2+1)'(sv[W]) + (W2+1)'(cv[W])) ==
    ((W2+1)'(addend) + (W2+1)'(op_a) * (W2+1)'(op_b) + (W2+1)'(op_c)));

  p_low_no_cin_r4: assert property (@(posedge clk) disable iff (!rst_n)
    res_c[W-1:0] == W'(addend[W-1:0] + op_a * op_b + op_c));

  p_lookahead_r6: assert property (@(posedge clk) disable iff (!rst_n)
    {cout_c, hi_half} == ((W+1)'(sv[W][W2-1:W]) + (W+1)'(cv[W][W2-1:W])
                          + (W+1)'(carry_in)));

  if (REG_OUT) begin : g_reg_chk
    p_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ({carry_out, result} == $past(ref_sum)));
  end

endmodule

// File: tb/fused_mul_add_tb_top.sv
`timescale 1ns/1ps
module fused_mul_add_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [3:0] a4, b4, c4;
  logic [7:0] s4;
  logic       ci4;
  logic [7:0] r4;
  logic       co4;

  logic [7:0]  a8, b8, c8;
  logic [15:0] s8;
  logic        ci8;
  logic [15:0] r8;
  logic        co8;

  fused_mul_add #(.W(4), .REG_OUT(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_a(a4), .op_b(b4), .op_c(c4),
    .addend(s4), .carry_in(ci4), .result(r4), .carry_out(co4));

  fused_mul_add #(.W(8), .REG_OUT(1'b1)) dut8_i (
    .clk(clk), .rst_n(rst_n), .op_a(a8), .op_b(b8), .op_c(c8),
    .addend(s8), .carry_in(ci8), .result(r8), .carry_out(co8));

  typedef struct {
    int          cyc;
    logic [8:0]  e4;
    logic [16:0] e8;
    string       tag;
  } item_t;

  item_t q[$];
  int cyc_cnt = 0;
  int checks = 0;
  int errors = 0;

  always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

  task automatic drive(input logic [3:0] a, input logic [3:0] b, input logic [3:0] c,
                       input logic [7:0] s, input logic ci, input string tag);
    item_t it;
    @(negedge clk);
    a4 = a; b4 = b; c4 = c; s4 = s; ci4 = ci;
    a8 = 8'($urandom); b8 = 8'($urandom); c8 = 8'($urandom);
    s8 = 16'($urandom); ci8 = 1'($urandom);
    it.cyc = cyc_cnt;
    it.e4  = 9'(s) + 9'(a) * 9'(b) + 9'(c) + (9'(ci) << 4);
    it.e8  = 17'(s8) + 17'(a8) * 17'(b8) + 17'(c8) + (17'(ci8) << 8);
    it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: pop items whose clock edge has passed
  always @(negedge clk) begin
    if (q.size() > 0 && q[0].cyc < cyc_cnt) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if ({co4, r4} !== it.e4) begin
        errors++;
        $display("FAIL %s W4: got %h expected %h", it.tag, {co4, r4}, it.e4);
      end
      checks++;
      if ({co8, r8} !== it.e8) begin
        errors++;
        $display("FAIL R6 W8: got %h expected %h", {co8, r8}, it.e8);
      end
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    a4 = '1; b4 = '1; c4 = '1; s4 = '1; ci4 = 1'b1;
    a8 = '1; b8 = '1; c8 = '1; s8 = '1; ci8 = 1'b1;
    repeat (3) @(negedge clk);
    // R3: outputs held at zero during reset despite nonzero operands
    checks++;
    if ({co4, r4} !== 9'h0) begin
      errors++;
      $display("FAIL R3 W4: got %h expected %h", {co4, r4}, 9'h0);
    end
    checks++;
    if ({co8, r8} !== 17'h0) begin
      errors++;
      $display("FAIL R3 W8: got %h expected %h", {co8, r8}, 17'h0);
    end
    rst_n = 1'b1;

    drive(4'h0, 4'h0, 4'h0, 8'h00, 1'b1, "R7");
    drive(4'hF, 4'hF, 4'hF, 8'hFF, 1'b1, "R5");
    drive(4'h0, 4'h0, 4'h1, 8'hFF, 1'b0, "R5");
    drive(4'h0, 4'h0, 4'h0, 8'hFF, 1'b0, "R5");
    drive(4'h3, 4'h5, 4'h9, 8'h3C, 1'b0, "R4");
    drive(4'h3, 4'h5, 4'h9, 8'h3C, 1'b1, "R4");
    drive(4'hA, 4'h6, 4'h2, 8'h11, 1'b0, "R2");
    drive(4'h1, 4'h2, 4'hF, 8'hE0, 1'b1, "R2");
    drive(4'hC, 4'h9, 4'h7, 8'h81, 1'b0, "R2");

    for (int ss = 0; ss < 4; ss++) begin
      logic [7:0] sval;
      case (ss)
        0: sval = 8'h00;
        1: sval = 8'hFF;
        2: sval = 8'hA5;
        default: sval = 8'h5A;
      endcase
      for (int v = 0; v < 8192; v++) begin
        drive(v[3:0], v[7:4], v[11:8], sval, v[12], "R1");
      end
    end

    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule